// File: doc/BRIEF.md
# Page Write Commit Controller

This block sits behind the serial front end of a small byte-wide serial memory and owns every decision about writing the array. It tracks the write-enable latch, collects the data bytes of a write instruction into a page buffer of `PAGE_BYTES` slots, and judges the clock count when chip select is released. When that count marks a whole number of data bytes, the block starts a self-timed commit. The commit raises `busy_o`, strobes each buffered byte into the array, and holds `busy_o` for `WRITE_CYCLES` system clocks.

The front end gives the block one-cycle events: a command byte, the byte address, each data byte, and the release of chip select. With the release it gives the count of serial clock rising edges seen since selection. Opcodes: 0x06 arms the latch, 0x04 clears it, 0x02 starts a write. All other codes are treated as foreign commands. The write-protect pin is active low. `WRITE_CYCLES` stands for the nonvolatile cycle time, about 5 ms typical and 10 ms worst case at the system clock rate, and a bench can set it small. It must be at least `PAGE_BYTES`.

Top module: `page_commit_ctrl`

## Requirements
- R1: After a synchronous reset, `busy_o`, `wel_o` and `arr_we_o` are all low.
- R2: A 0x06 command sets `wel_o` on the edge where `cs_rise_i` is sampled, but only if `edge_cnt_i` is exactly 8 at that point. If any other count is seen at release, `wel_o` stays clear.
- R3: A 0x04 command clears `wel_o` on the edge where its `cmd_valid_i` is sampled.
- R4: While `wp_n_i` is low, `wel_o` is cleared on each edge. A write session during which `wp_n_i` went low before release writes nothing.
- R5: A 0x02 command issued while `wel_o` is clear causes no strobe and no busy period.
- R6: A commit starts only if the release count is 24, 32, 40 or 48 (that is, 8·(2+n) for n from 1 to `PAGE_BYTES`). At any other count nothing is written, `busy_o` stays low and `wel_o` keeps its value.
- R7: On a commit, `busy_o` is high starting the cycle after the release edge, for exactly `WRITE_CYCLES` cycles. `wel_o` is low from the edge where `busy_o` falls.
- R8: During the first `PAGE_BYTES` busy cycles, cycle k (counting from 0) presents page offset k. `arr_we_o` is high only for an offset that received a byte, with `arr_addr_o` = {page, k} and `arr_wdata_o` = the last byte received at that offset.
- R9: The offset of the first data byte is the low two address bits. Each following byte takes the next offset, and the offset wraps from the last offset of the page back to 0. The page bits of the address do not change.
- R10: While `busy_o` is high, command, address, data and release events are ignored. A low `wp_n_i` during that time does not stop the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle pulse: command byte received |
| cmd_code_i | input | 8 | Command opcode |
| addr_valid_i | input | 1 | One-cycle pulse: byte address received |
| addr_i | input | ADDR_W | Byte address |
| data_valid_i | input | 1 | One-cycle pulse: data byte received |
| data_i | input | DATA_W | Data byte |
| edge_cnt_i | input | CNT_W | Serial clock rising edges since selection |
| cs_rise_i | input | 1 | One-cycle pulse: chip select released |
| wp_n_i | input | 1 | Write protect, active low |
| arr_we_o | output | 1 | Array byte write strobe |
| arr_addr_o | output | ADDR_W | Array byte address |
| arr_wdata_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Write cycle in progress |
| wel_o | output | 1 | Write-enable latch state |

## Verification
Latch changes from a command or a release (R2, R3, R4) show one cycle after the edge that samples the event. The bench drives each event at a falling edge and reads `wel_o` at the next falling edge. The strobe for offset k is present in the (k+1)-th cycle after the release edge. `busy_o` is high from the first through the `WRITE_CYCLES`-th falling edge after release and low at the next one. The commit check samples exactly those falling edges and compares each against offsets, masks and bytes that bench functions work out from the start offset and byte count. Rejected releases are checked over several later cycles for a quiet strobe and busy.

// File: rtl/pcc_pkg.sv
// Package: opcodes and session kinds shared by the commit controller.
package pcc_pkg;
    localparam logic [7:0] OP_ARM   = 8'h06;
    localparam logic [7:0] OP_DISARM = 8'h04;
    localparam logic [7:0] OP_WRITE = 8'h02;

    // Kind of the serial session currently open.
    typedef enum logic [1:0] {
        SES_IDLE  = 2'd0,
        SES_ARM   = 2'd1,
        SES_WRITE = 2'd2,
        SES_OTHER = 2'd3
    } ses_t;
endpackage

// File: rtl/pcc_wel_latch.sv
// Write-enable latch. Clear requests win over set requests.
// Assumes set_i and clr_i are already qualified by the caller.
module pcc_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);
    logic wel_q;

    // Hold latch state; reset and clear take priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)     wel_q <= 1'b0;
        else if (clr_i) wel_q <= 1'b0;
        else if (set_i) wel_q <= 1'b1;
    end

    assign wel_o = wel_q;
endmodule

// File: rtl/pcc_page_buf.sv
// Page buffer: page number, one byte per offset, and a mask of the offsets
// that received data. The offset pointer wraps within the page.
// Assumes PAGE_BYTES is a power of two and load_i comes before wr_i.
module pcc_page_buf #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 4,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [ADDR_W-1:0]     base_addr_i,
    input  logic                  wr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [OFF_W-1:0]      slot_sel_i,
    output logic [PAGE_W-1:0]     page_o,
    output logic [DATA_W-1:0]     slot_data_o,
    output logic [PAGE_BYTES-1:0] mask_o
);
    logic [PAGE_W-1:0]                  page_q;
    logic [OFF_W-1:0]                   ptr_q;
    logic [PAGE_BYTES-1:0]              mask_q;
    logic [PAGE_BYTES-1:0][DATA_W-1:0]  bytes_q;

    // Page number and offset pointer: loaded from the address, pointer advances per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            ptr_q  <= '0;
        end else if (load_i) begin
            page_q <= base_addr_i[ADDR_W-1:OFF_W];
            ptr_q  <= base_addr_i[OFF_W-1:0];
        end else if (wr_i) begin
            ptr_q  <= ptr_q + 1'b1;
        end
    end

    // Byte slots and received mask: a new address empties the mask, a byte fills its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            bytes_q <= '0;
        end else if (load_i) begin
            mask_q  <= '0;
        end else if (wr_i) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (ptr_q == OFF_W'(i)) begin
                    bytes_q[i] <= wdata_i;
                    mask_q[i]  <= 1'b1;
                end
            end
        end
    end

    assign page_o      = page_q;
    assign mask_o      = mask_q;
    assign slot_data_o = bytes_q[slot_sel_i];
endmodule

// File: rtl/pcc_commit_seq.sv
// Self-timed commit sequencer. A start raises busy for WRITE_CYCLES cycles.
// The first PAGE_BYTES of those cycles step through the page offsets in order.
// Assumes WRITE_CYCLES >= PAGE_BYTES and start_i only while idle.
module pcc_commit_seq #(
    parameter int PAGE_BYTES   = 4,
    parameter int WRITE_CYCLES = 50000,
    localparam int OFF_W       = $clog2(PAGE_BYTES),
    localparam int TMR_W       = $clog2(WRITE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             slot_act_o,
    output logic [OFF_W-1:0] slot_o,
    output logic             done_o
);
    logic             busy_q;
    logic [TMR_W-1:0] timer_q;
    logic [OFF_W:0]   sweep_q;
    logic             sweeping;

    assign sweeping = busy_q && (sweep_q < (OFF_W+1)'(PAGE_BYTES));

    // Busy flag and cycle timer: load on start, count down, drop busy at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            timer_q <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q  <= 1'b1;
                timer_q <= TMR_W'(WRITE_CYCLES - 1);
            end
        end else if (timer_q == '0) begin
            busy_q  <= 1'b0;
        end else begin
            timer_q <= timer_q - 1'b1;
        end
    end

    // Offset sweep: restart at zero on start, step once per cycle until the page is covered.
    always_ff @(posedge clk) begin
        if (!rst_n)               sweep_q <= '0;
        else if (!busy_q)         sweep_q <= '0;
        else if (sweeping)        sweep_q <= sweep_q + 1'b1;
    end

    assign busy_o     = busy_q;
    assign slot_act_o = sweeping;
    assign slot_o     = sweep_q[OFF_W-1:0];
    assign done_o     = busy_q && (timer_q == '0);
endmodule

// File: rtl/page_commit_ctrl.sv
// Page write commit controller, top level.
// Tracks the session kind, drives the write-enable latch, fills the page
// buffer and starts the commit when chip select is released on a byte
// boundary that closes one to PAGE_BYTES data bytes.
// Assumes one-cycle event pulses from the front end and at most one
// command per session.
module page_commit_ctrl #(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 4,
    parameter int CNT_W        = 7,
    parameter int WRITE_CYCLES = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [7:0]        cmd_code_i,
    input  logic              addr_valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              data_valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  edge_cnt_i,
    input  logic              cs_rise_i,
    input  logic              wp_n_i,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_wdata_o,
    output logic              busy_o,
    output logic              wel_o
);
    import pcc_pkg::*;

    localparam int OFF_W    = $clog2(PAGE_BYTES);
    localparam int PAGE_W   = ADDR_W - OFF_W;
    localparam int ARM_CNT  = 8;

    ses_t                  ses_q;
    logic                  live;
    logic                  busy;
    logic                  wel;
    logic                  wel_set;
    logic                  wel_clr;
    logic                  commit_start;
    logic                  seq_done;
    logic                  slot_act;
    logic [OFF_W-1:0]      slot;
    logic [PAGE_W-1:0]     page;
    logic [DATA_W-1:0]     slot_data;
    logic [PAGE_BYTES-1:0] mask;
    logic [PAGE_BYTES-1:0] cnt_hit;
    logic                  cnt_ok;
    logic                  buf_load;
    logic                  buf_wr;

    // Front-end events only count while no commit is running.
    assign live = !busy;

    // One comparator per legal byte count: release after 8*(2+n) edges.
    for (genvar n = 1; n <= PAGE_BYTES; n++) begin : g_cnt
        assign cnt_hit[n-1] = (edge_cnt_i == CNT_W'(8 * (2 + n)));
    end
    assign cnt_ok = |cnt_hit;

    // Session kind: closed by release, opened by the command byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ses_q <= SES_IDLE;
        end else if (live && cs_rise_i) begin
            ses_q <= SES_IDLE;
        end else if (live && cmd_valid_i) begin
            case (cmd_code_i)
                OP_ARM:   ses_q <= SES_ARM;
                OP_WRITE: ses_q <= wel ? SES_WRITE : SES_OTHER;
                default:  ses_q <= SES_OTHER;
            endcase
        end
    end

    assign wel_set = live && cs_rise_i && (ses_q == SES_ARM)
                     && (edge_cnt_i == CNT_W'(ARM_CNT)) && wp_n_i;
    assign wel_clr = !wp_n_i || seq_done
                     || (live && cmd_valid_i && (cmd_code_i == OP_DISARM));

    assign buf_load = live && addr_valid_i && (ses_q == SES_WRITE);
    assign buf_wr   = live && data_valid_i && (ses_q == SES_WRITE);

    assign commit_start = live && cs_rise_i && (ses_q == SES_WRITE)
                          && wel && wp_n_i && cnt_ok && (|mask);

    pcc_wel_latch u_wel (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (wel_set),
        .clr_i (wel_clr),
        .wel_o (wel)
    );

    pcc_page_buf #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (buf_load),
        .base_addr_i (addr_i),
        .wr_i        (buf_wr),
        .wdata_i     (data_i),
        .slot_sel_i  (slot),
        .page_o      (page),
        .slot_data_o (slot_data),
        .mask_o      (mask)
    );

    pcc_commit_seq #(
        .PAGE_BYTES   (PAGE_BYTES),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (commit_start),
        .busy_o     (busy),
        .slot_act_o (slot_act),
        .slot_o     (slot),
        .done_o     (seq_done)
    );

    assign arr_we_o    = slot_act && mask[slot];
    assign arr_addr_o  = {page, slot};
    assign arr_wdata_o = slot_data;
    assign busy_o      = busy;
    assign wel_o       = wel;
endmodule

// File: rtl/page_commit_ctrl_chk.sv
// Checker for page_commit_ctrl: port-level timing rules of latch, commit
// and strobes. Bound to every instance of the top module.
module page_commit_ctrl_chk #(
    parameter int ADDR_W       = 8,
    parameter int PAGE_BYTES   = 4,
    parameter int CNT_W        = 7,
    parameter int WRITE_CYCLES = 50000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  edge_cnt_i,
    input logic              cs_rise_i,
    input logic              wp_n_i,
    input logic              arr_we_o,
    input logic [ADDR_W-1:0] arr_addr_o,
    input logic              busy_o,
    input logic              wel_o
);
    localparam int OFF_W    = $clog2(PAGE_BYTES);
    localparam int LAST_CNT = 8 * (2 + PAGE_BYTES);

    int unsigned busy_len;

    // Length of the current busy run, for the window check.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_len <= 0;
        else if (busy_o) busy_len <= busy_len + 1;
        else             busy_len <= 0;
    end

    AST_LATCH_ARM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_o) |-> $past(cs_rise_i && (edge_cnt_i == CNT_W'(8)))); // R2

    AST_PROTECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n_i |=> !wel_o); // R4

    AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cs_rise_i && (edge_cnt_i[2:0] == 3'd0)
                                && (edge_cnt_i >= CNT_W'(24))
                                && (edge_cnt_i <= CNT_W'(LAST_CNT)))); // R6

    AST_START_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(wel_o)); // R5

    AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_len == WRITE_CYCLES)); // R7

    AST_LATCH_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !wel_o); // R7

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o); // R8

    AST_STROBE_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we_o && $past(arr_we_o)) |->
            (arr_addr_o[ADDR_W-1:OFF_W] == $past(arr_addr_o[ADDR_W-1:OFF_W]))); // R9
endmodule

bind page_commit_ctrl page_commit_ctrl_chk #(
    .ADDR_W       (ADDR_W),
    .PAGE_BYTES   (PAGE_BYTES),
    .CNT_W        (CNT_W),
    .WRITE_CYCLES (WRITE_CYCLES)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_cnt_i (edge_cnt_i),
    .cs_rise_i  (cs_rise_i),
    .wp_n_i     (wp_n_i),
    .arr_we_o   (arr_we_o),
    .arr_addr_o (arr_addr_o),
    .busy_o     (busy_o),
    .wel_o      (wel_o)
);

// File: tb/page_commit_ctrl_tb_top.sv
// Bench for page_commit_ctrl: directed corner cases plus seeded random writes.
module page_commit_ctrl_tb_top;
    localparam int WC = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic       addr_valid = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       data_valid = 1'b0;
    logic [7:0] data = 8'h00;
    logic [6:0] edge_cnt = 7'd0;
    logic       cs_rise = 1'b0;
    logic       wp_n = 1'b1;
    logic       arr_we;
    logic [7:0] arr_addr;
    logic [7:0] arr_wdata;
    logic       busy;
    logic       wel;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    page_commit_ctrl #(.WRITE_CYCLES(WC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
        .addr_valid_i(addr_valid), .addr_i(addr),
        .data_valid_i(data_valid), .data_i(data),
        .edge_cnt_i(edge_cnt), .cs_rise_i(cs_rise), .wp_n_i(wp_n),
        .arr_we_o(arr_we), .arr_addr_o(arr_addr), .arr_wdata_o(arr_wdata),
        .busy_o(busy), .wel_o(wel)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_cmd(logic [7:0] code);
        edge_cnt = 7'd8; cmd_code = code; cmd_valid = 1'b1;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic send_addr(logic [7:0] a);
        edge_cnt = 7'd16; addr = a; addr_valid = 1'b1;
        tick();
        addr_valid = 1'b0;
    endtask

    task automatic send_data(logic [7:0] d);
        edge_cnt = edge_cnt + 7'd8; data = d; data_valid = 1'b1;
        tick();
        data_valid = 1'b0;
    endtask

    task automatic extra_clocks(int k);
        edge_cnt = edge_cnt + 7'(k);
        tick();
    endtask

    // Release: returns at the first falling edge after the sampling edge.
    task automatic release_cs();
        cs_rise = 1'b1;
        tick();
        cs_rise = 1'b0; edge_cnt = 7'd0;
    endtask

    task automatic arm();
        send_cmd(8'h06);
        release_cs();
        chk("R2 latch set by arm at count 8", 32'(wel), 32'd1);
    endtask

    function automatic logic [3:0] exp_mask(int off, int n);
        logic [3:0] m = 4'b0;
        for (int i = 0; i < n; i++) m[(off + i) % 4] = 1'b1;
        return m;
    endfunction

    function automatic logic [7:0] exp_byte(int off, int n, logic [7:0] b [4], int slot);
        logic [7:0] v = 8'h00;
        for (int i = 0; i < n; i++) if ((off + i) % 4 == slot) v = b[i];
        return v;
    endfunction

    // Expects strobes for offsets 0..3 in the four cycles after release, then the busy window.
    task automatic check_commit(int pg, int off, int n, logic [7:0] b [4]);
        logic [3:0] m = exp_mask(off, n);
        for (int s = 0; s < 4; s++) begin
            chk("R7 busy during strobes", 32'(busy), 32'd1);
            chk("R8 strobe per offset", 32'(arr_we), 32'(m[s]));
            if (m[s]) begin
                chk("R9 strobe address", 32'(arr_addr), 32'(pg * 4 + s));
                chk("R8 strobe data", 32'(arr_wdata), 32'(exp_byte(off, n, b, s)));
            end
            tick();
        end
        repeat (WC - 5) tick();
        chk("R7 busy in last cycle", 32'(busy), 32'd1);
        tick();
        chk("R7 busy ends", 32'(busy), 32'd0);
        chk("R7 latch cleared at end", 32'(wel), 32'd0);
    endtask

    task automatic check_quiet(string req);
        for (int i = 0; i < 6; i++) begin
            chk(req, 32'({busy, arr_we}), 32'd0);
            tick();
        end
    endtask

    task automatic write_session(int pg, int off, int n, logic [7:0] b [4], int extra);
        send_cmd(8'h02);
        send_addr(8'(pg * 4 + off));
        for (int i = 0; i < n; i++) send_data(b[i]);
        if (extra > 0) extra_clocks(extra);
        release_cs();
    endtask

    initial begin
        logic [7:0] b [4];
        void'($urandom(32'd20240611));
        repeat (3) tick();
        chk("R1 reset outputs", 32'({busy, wel, arr_we}), 32'd0);
        rst_n = 1'b1;
        tick();
        chk("R1 after reset release", 32'({busy, wel, arr_we}), 32'd0);

        // R2: arm command followed by more clocks is dropped
        send_cmd(8'h06);
        extra_clocks(1);
        release_cs();
        chk("R2 arm with count 9 ignored", 32'(wel), 32'd0);

        // R3: disarm clears the latch
        arm();
        send_cmd(8'h04);
        chk("R3 disarm clears latch", 32'(wel), 32'd0);
        release_cs();

        // R5: write without latch
        b = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
        write_session(5, 0, 1, b, 0);
        check_quiet("R5 write without latch");

        // R9: start offset 3, three bytes wrap to offsets 0 and 1
        arm();
        b = '{8'h11, 8'h22, 8'h33, 8'h44};
        write_session(9, 3, 3, b, 0);
        check_commit(9, 3, 3, b);

        // R4: protect low mid-session
        arm();
        send_cmd(8'h02);
        send_addr(8'h20);
        send_data(8'h5A);
        wp_n = 1'b0;
        tick();
        chk("R4 protect clears latch", 32'(wel), 32'd0);
        wp_n = 1'b1;
        release_cs();
        check_quiet("R4 write after protect");

        // R6: five bytes (count 56) and address only (count 16)
        arm();
        send_cmd(8'h02);
        send_addr(8'h40);
        for (int i = 0; i < 5; i++) send_data(8'(i + 1));
        release_cs();
        check_quiet("R6 count 56 rejected");
        chk("R6 latch kept", 32'(wel), 32'd1);
        send_cmd(8'h02);
        send_addr(8'h44);
        release_cs();
        check_quiet("R6 count 16 rejected");

        // R10: protect low during busy does not stop strobes
        arm();
        b = '{8'h9C, 8'h3E, 8'h00, 8'h00};
        write_session(2, 0, 2, b, 0);
        wp_n = 1'b0;
        check_commit(2, 0, 2, b);
        wp_n = 1'b1;

        // R10: arm and write sessions during busy are ignored
        arm();
        b = '{8'h77, 8'h00, 8'h00, 8'h00};
        write_session(7, 1, 1, b, 0);
        send_cmd(8'h06);
        release_cs();
        send_cmd(8'h02);
        send_addr(8'h10);
        send_data(8'hEE);
        release_cs();
        repeat (WC - 7) tick();
        chk("R10 busy not restarted", 32'(busy), 32'd1);
        tick();
        chk("R10 busy ends on time", 32'(busy), 32'd0);
        chk("R10 arm during busy ignored", 32'(wel), 32'd0);
        check_quiet("R10 write during busy ignored");

        // Random writes, some released off a byte boundary
        for (int it = 0; it < 40; it++) begin
            int pg = int'($urandom % 64);
            int off = int'($urandom % 4);
            int n = 1 + int'($urandom % 4);
            bit bad = ($urandom % 4) == 0;
            for (int i = 0; i < 4; i++) b[i] = 8'($urandom);
            arm();
            write_session(pg, off, n, b, bad ? 1 + int'($urandom % 7) : 0);
            if (bad) begin
                check_quiet("R6 random off-boundary release");
                chk("R6 latch kept after reject", 32'(wel), 32'd1);
                send_cmd(8'h04);
                release_cs();
            end else begin
                check_commit(pg, off, n, b);
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule